// File: doc/BRIEF.md
# Performance Counter Enable and Overflow Unit

This block holds one free-running cycle counter and a set of event counters, all 32 bits wide. Each event counter has its own single-cycle event pulse input. Software reaches the block through a simple register port with read and write strobes and a privilege input. Two enable registers share one stored enable vector. A write of ones to the first turns counters on, and a write of ones to the second turns them off. Both registers read back the same vector.

A control register holds a master run bit, which stops every counter while keeping the stored enables, and a user-access bit. When an access comes from unprivileged code and the user-access bit is clear, the access is refused. The block keeps a sticky overflow flag for every counter. A flag is set when its counter wraps, and software clears it by writing a one to it.

Register map (4-bit address): 0 control (bit 0 run, bit 1 user access), 1 enable-set, 2 enable-clear, 3 overflow flags, 4 cycle counter, 8+i event counter i. In the enable and overflow registers, bit i belongs to event counter i and bit 31 to the cycle counter.

Top module: `perf_counter_unit`

## Requirements
- R1: Writing the enable-set register (address 1) enables every counter whose bit is 1 and leaves the others unchanged. Reads of address 1 and address 2 both return the enable vector.
- R2: Writing the enable-clear register (address 2) disables every counter whose bit is 1 and leaves the counters with a 0 bit unchanged.
- R3: In the enable and overflow registers, bits NUM_EVT to 30 read as zero and ignore writes.
- R4: Event counter i (address 8+i) adds one at a clock edge where its event pulse is high, its enable bit i is 1 and the run bit is 1.
- R5: The cycle counter (address 4) adds one at every clock edge where enable bit 31 and the run bit are both 1.
- R6: While the run bit is 0, no counter changes except through a software write, and the stored enable bits keep their values.
- R7: A counter that wraps from all ones to zero sets its overflow flag (address 3) at that edge.
- R8: Writing 1 to an overflow flag bit clears that flag. Writing 0 leaves the flag unchanged.
- R9: If a wrap and a software clear hit the same flag in the same cycle, the flag ends up set.
- R10: When priv is 0 and the user-access bit is 0, an access returns read data 0, changes no register, and raises acc_err in that cycle. Otherwise acc_err is 0.
- R11: The control register reads back {30'b0, user, run} and resets to 0. A software write to a counter loads that value and takes priority over an increment in the same cycle. After reset the overflow flags and all counters are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| priv | input | 1 | Access is privileged |
| acc_addr | input | 4 | Register address |
| acc_wr | input | 1 | Write strobe |
| acc_rd | input | 1 | Read strobe |
| acc_wdata | input | 32 | Write data |
| acc_rdata | output | 32 | Read data, valid in the cycle of acc_rd |
| acc_err | output | 1 | Access refused |
| evt_pulse | input | NUM_EVT | Event pulses, one per event counter |

## Verification
Two functions can fall in the same cycle: a counter wrapping, which sets its overflow flag, and a software write-one that clears the same flag. A second such pair is a software load of a counter and an increment of that counter. The bench preloads the cycle counter to three below the wrap point and times a clear write so that it lands on the exact edge where the counter wraps. It then expects the flag to read back as set. Random traffic also preloads counters to values near the wrap point while events and clear writes arrive, and a bench model judges the result on every read.

// File: rtl/perf_counter_unit.sv
module perf_counter_unit #(
  parameter int NUM_EVT = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               priv,
  input  logic [3:0]         acc_addr,
  input  logic               acc_wr,
  input  logic               acc_rd,
  input  logic [31:0]        acc_wdata,
  output logic [31:0]        acc_rdata,
  output logic               acc_err,
  input  logic [NUM_EVT-1:0] evt_pulse
);
  localparam logic [3:0]  A_CTRL = 4'd0;
  localparam logic [3:0]  A_ENS  = 4'd1;
  localparam logic [3:0]  A_ENC  = 4'd2;
  localparam logic [3:0]  A_OVF  = 4'd3;
  localparam logic [3:0]  A_CYC  = 4'd4;
  localparam int          EVT_BASE = 8;
  localparam logic [31:0] EVT_MASK = (32'h1 << NUM_EVT) - 32'h1;
  localparam logic [31:0] ALL_MASK = EVT_MASK | 32'h8000_0000;

  logic        run_q, uen_q;
  logic [31:0] en_q, ovf_q, cyc_q;
  logic [31:0] evt_q [NUM_EVT];
  logic [31:0] wrap_vec;

  logic access_ok, wr_ok, cyc_wr, cyc_inc;
  assign access_ok = priv | uen_q;
  assign acc_err   = (acc_wr | acc_rd) & ~access_ok;
  assign wr_ok     = acc_wr & access_ok;
  assign cyc_wr    = wr_ok && acc_addr == A_CYC;
  assign cyc_inc   = run_q & en_q[31];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      uen_q <= 1'b0;
    end else if (wr_ok && acc_addr == A_CTRL) begin
      run_q <= acc_wdata[0];
      uen_q <= acc_wdata[1];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      en_q <= '0;
    else if (wr_ok && acc_addr == A_ENS)
      en_q <= en_q | (acc_wdata & ALL_MASK);
    else if (wr_ok && acc_addr == A_ENC)
      en_q <= en_q & ~(acc_wdata & ALL_MASK);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      cyc_q <= '0;
    else if (cyc_wr)
      cyc_q <= acc_wdata;
    else if (cyc_inc)
      cyc_q <= cyc_q + 32'd1;
  end

  always_comb begin
    wrap_vec = '0;
    wrap_vec[31] = cyc_inc && !cyc_wr && cyc_q == 32'hFFFF_FFFF;
    for (int i = 0; i < NUM_EVT; i++) begin
      wrap_vec[i] = run_q && en_q[i] && evt_pulse[i] &&
                    !(wr_ok && acc_addr == 4'(EVT_BASE + i)) &&
                    evt_q[i] == 32'hFFFF_FFFF;
    end
  end

  for (genvar g = 0; g < NUM_EVT; g++) begin : g_evt
    logic hit_wr, hit_inc;
    assign hit_wr  = wr_ok && acc_addr == 4'(EVT_BASE + g);
    assign hit_inc = run_q & en_q[g] & evt_pulse[g];
    always_ff @(posedge clk) begin
      if (!rst_n)
        evt_q[g] <= '0;
      else if (hit_wr)
        evt_q[g] <= acc_wdata;
      else if (hit_inc)
        evt_q[g] <= evt_q[g] + 32'd1;
    end
  end

  logic [31:0] ovf_clr;
  assign ovf_clr = (wr_ok && acc_addr == A_OVF) ? (acc_wdata & ALL_MASK) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n)
      ovf_q <= '0;
    else
      ovf_q <= (ovf_q & ~ovf_clr) | wrap_vec;
  end

  always_comb begin
    acc_rdata = '0;
    if (acc_rd && access_ok) begin
      case (acc_addr)
        A_CTRL:        acc_rdata = {30'b0, uen_q, run_q};
        A_ENS, A_ENC:  acc_rdata = en_q;
        A_OVF:         acc_rdata = ovf_q;
        A_CYC:         acc_rdata = cyc_q;
        default: begin
          for (int i = 0; i < NUM_EVT; i++)
            if (acc_addr == 4'(EVT_BASE + i)) acc_rdata = evt_q[i];
        end
      endcase
    end
  end
endmodule

// File: rtl/perf_counter_checker.sv
module perf_counter_checker #(
  parameter int NUM_EVT = 4
) (
  input logic        clk,
  input logic        rst_n,
  input logic [3:0]  acc_addr,
  input logic        acc_wr,
  input logic        acc_rd,
  input logic [31:0] acc_rdata,
  input logic        acc_err,
  input logic        run_q,
  input logic        uen_q,
  input logic [31:0] en_q,
  input logic [31:0] ovf_q,
  input logic [31:0] cyc_q
);
  localparam logic [31:0] MID_MASK = ~((32'h1 << NUM_EVT) - 32'h1) & 32'h7FFF_FFFF;
  logic cyc_load;
  assign cyc_load = acc_wr && !acc_err && acc_addr == 4'd4;

  a_r10_zero_data: assert property (@(posedge clk) disable iff (!rst_n)
    acc_err |-> acc_rdata == 32'h0);
  a_r10_no_change: assert property (@(posedge clk) disable iff (!rst_n)
    acc_err |=> en_q == $past(en_q) && run_q == $past(run_q) && uen_q == $past(uen_q));
  a_r3_mid_bits_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_rd && !acc_err && acc_addr >= 4'd1 && acc_addr <= 4'd3) |-> (acc_rdata & MID_MASK) == 32'h0);
  a_r5_cycle_step: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && en_q[31] && !cyc_load) |=> cyc_q == $past(cyc_q) + 32'd1);
  a_r6_cycle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_q && !cyc_load) |=> cyc_q == $past(cyc_q));
  a_r7_flag_from_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf_q[31]) |-> $past(cyc_q) == 32'hFFFF_FFFF);
  a_r9_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && en_q[31] && !cyc_load && cyc_q == 32'hFFFF_FFFF) |=> ovf_q[31]);
endmodule

bind perf_counter_unit perf_counter_checker #(.NUM_EVT(NUM_EVT)) u_chk (
  .clk(clk), .rst_n(rst_n), .acc_addr(acc_addr), .acc_wr(acc_wr), .acc_rd(acc_rd),
  .acc_rdata(acc_rdata), .acc_err(acc_err), .run_q(run_q), .uen_q(uen_q),
  .en_q(en_q), .ovf_q(ovf_q), .cyc_q(cyc_q)
);

// File: tb/perf_counter_unit_test.sv
module perf_counter_unit_test;
  localparam int CLK_PERIOD = 10;
  localparam int N = 4;
  localparam logic [31:0] ALL = ((32'h1 << N) - 32'h1) | 32'h8000_0000;

  logic clk = 0, rst_n = 0, priv = 0, acc_wr = 0, acc_rd = 0;
  logic [3:0] acc_addr = 0;
  logic [31:0] acc_wdata = 0, acc_rdata;
  logic acc_err;
  logic [N-1:0] evt_pulse = 0;

  perf_counter_unit #(.NUM_EVT(N)) uut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, fails = 0;
  bit done = 0;
  bit m_run, m_uen;
  logic [31:0] m_en, m_ovf, m_cyc;
  logic [31:0] m_evt [N];

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  function automatic logic [31:0] exp_read(input logic [3:0] a);
    case (a)
      4'd0: return {30'b0, m_uen, m_run};
      4'd1, 4'd2: return m_en;
      4'd3: return m_ovf;
      4'd4: return m_cyc;
      default: begin
        for (int i = 0; i < N; i++) if (a == 4'(8 + i)) return m_evt[i];
        return 32'h0;
      end
    endcase
  endfunction

  function automatic string tag_of(input logic [3:0] a);
    case (a)
      4'd0: return "R11";
      4'd1: return "R1";
      4'd2: return "R2";
      4'd3: return "R8";
      4'd4: return "R5";
      default: return "R4";
    endcase
  endfunction

  task automatic model_edge(input bit wr, input logic [3:0] a, input logic [31:0] d,
                            input bit p, input logic [N-1:0] ev);
    bit wok;
    logic [31:0] wrap, clr;
    wok = wr && (p || m_uen);
    wrap = 0;
    if (wok && a == 4'd4) m_cyc = d;
    else if (m_run && m_en[31]) begin
      if (m_cyc == 32'hFFFF_FFFF) wrap[31] = 1;
      m_cyc = m_cyc + 1;
    end
    for (int i = 0; i < N; i++) begin
      if (wok && a == 4'(8 + i)) m_evt[i] = d;
      else if (m_run && m_en[i] && ev[i]) begin
        if (m_evt[i] == 32'hFFFF_FFFF) wrap[i] = 1;
        m_evt[i] = m_evt[i] + 1;
      end
    end
    clr = (wok && a == 4'd3) ? (d & ALL) : 0;
    m_ovf = (m_ovf & ~clr) | wrap;
    if (wok && a == 4'd1) m_en = m_en | (d & ALL);
    if (wok && a == 4'd2) m_en = m_en & ~(d & ALL);
    if (wok && a == 4'd0) begin m_run = d[0]; m_uen = d[1]; end
  endtask

  task automatic step(input bit wr, input bit rd, input logic [3:0] a, input logic [31:0] d,
                      input bit p, input logic [N-1:0] ev);
    bit ok;
    @(negedge clk);
    acc_wr = wr; acc_rd = rd; acc_addr = a; acc_wdata = d; priv = p; evt_pulse = ev;
    #1;
    ok = p || m_uen;
    check("R10", {31'b0, acc_err}, {31'b0, (wr || rd) && !ok});
    if (rd) check(ok ? tag_of(a) : "R10", acc_rdata, ok ? exp_read(a) : 32'h0);
    @(posedge clk);
    model_edge(wr, a, d, p, ev);
  endtask

  task automatic wr_p(input logic [3:0] a, input logic [31:0] d);
    step(1, 0, a, d, 1, '0);
  endtask
  task automatic rd_p(input logic [3:0] a);
    step(0, 1, a, 0, 1, '0);
  endtask

  initial begin
    repeat (CLK_PERIOD * 20000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    m_run = 0; m_uen = 0; m_en = 0; m_ovf = 0; m_cyc = 0;
    for (int i = 0; i < N; i++) m_evt[i] = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    // R11 reset state
    rd_p(0); rd_p(3); rd_p(4); rd_p(8);
    // R1 / R3 enable-set, readback through both addresses
    wr_p(2, 32'hFFFF_FFFF);
    wr_p(1, 32'h8000_0001); rd_p(1); rd_p(2);
    wr_p(1, 32'h0); rd_p(2);
    wr_p(1, 32'hFFFF_FFFF); rd_p(1);
    check("R3", exp_read(1), ALL);
    // R2
    wr_p(2, 32'h0000_0002); rd_p(2);
    wr_p(2, 32'h0); rd_p(1);
    // R4 / R5 counting with run on
    wr_p(0, 32'h1);
    for (int k = 0; k < 6; k++) step(0, 0, 0, 0, 1, 4'(k + 5));
    rd_p(4); rd_p(8); rd_p(9); rd_p(10); rd_p(11);
    // R7 / R9 wrap coinciding with a software clear
    wr_p(3, 32'hFFFF_FFFF);
    wr_p(4, 32'hFFFF_FFFD);
    step(0, 0, 0, 0, 1, 0);
    step(0, 0, 0, 0, 1, 0);
    wr_p(3, 32'h8000_0000);
    rd_p(3);
    check("R9", {31'b0, exp_read(3) >> 31}, 32'h1);
    // R8 write zero keeps, write one clears
    wr_p(3, 32'h0); rd_p(3);
    wr_p(3, 32'h8000_0000); rd_p(3);
    // R7 event counter wrap
    wr_p(8, 32'hFFFF_FFFF);
    step(0, 0, 0, 0, 1, 4'h1); rd_p(3); rd_p(8);
    // R6 master off keeps enables and freezes counters
    wr_p(0, 32'h0);
    for (int k = 0; k < 4; k++) step(0, 0, 0, 0, 1, 4'hF);
    rd_p(4); rd_p(8); rd_p(1);
    check("R6", exp_read(1), ALL & ~32'h2);
    // R10 user access denied, then allowed
    step(0, 1, 4'd1, 0, 0, 0);
    step(1, 0, 4'd2, 32'hFFFF_FFFF, 0, 0);
    rd_p(1);
    wr_p(0, 32'h3);
    step(0, 1, 4'd4, 0, 0, 0);
    // random traffic
    void'($urandom(32'd1234));
    for (int k = 0; k < 4000; k++) begin
      logic [3:0] a;
      logic [31:0] d;
      bit wr, rd, p;
      a = ($urandom % 4 == 0) ? 4'(8 + $urandom % (N + 1)) : 4'($urandom % 6);
      d = $urandom;
      if ($urandom % 3 == 0) d = 32'hFFFF_FFF0 | ($urandom % 16);
      if (a == 4'd0) d = {30'b0, 1'b1, 1'($urandom % 8 != 0)};
      if (a == 4'd0 && $urandom % 4 == 0) d[1] = 0;
      wr = ($urandom % 4 == 0);
      rd = !wr;
      p = ($urandom % 4 != 0);
      step(wr, rd, a, d, p, N'($urandom));
    end
    step(0, 0, 0, 0, 1, 0);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule